// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block timestamps transitions on one asynchronous input pin. The pin is brought into the clock domain through a synchronizer chain. Its edges are then qualified by a 3-bit mode field. The modes cover single polarity, both polarities, both polarities starting from a chosen polarity, and divided rising-edge counts. On each qualifying event the block copies a time-base value into a small FIFO. The time base is one of two free-running 16-bit timer inputs, or both of them joined into one 32-bit value.

Software-facing logic outside the block drives the configuration inputs. It pops timestamps through a simple read strobe and watches three outputs: a not-empty flag, a sticky overflow flag, and a one-cycle interrupt pulse. The pulse fires when the number of stored timestamps reaches a programmable level.

Top module: `input_capture_chan`

## Requirements
- R1: After reset, buf_ne, ovf and irq are 0 and rd_data is 0.
- R2: A pin transition present before clock edge k is stored at edge k+2. The stored value is the time base presented during the cycle that ends at edge k+2. buf_ne is 1 after edge k+2.
- R3: cfg_mode 1 captures rising edges only, cfg_mode 2 falling edges only, and cfg_mode 3 both edges.
- R4: With cfg_mode 4, edges are ignored until the first edge of the polarity chosen by cfg_first_rise (1 = rising, 0 = falling). That edge is captured, and from then on every edge is captured.
- R5: cfg_mode 5 captures every 4th rising edge and cfg_mode 6 every 16th rising edge. Rising edges are counted from the time the mode was last off.
- R6: With cfg_wide = 1, the stored value is {tmr_b, tmr_a}. Otherwise cfg_tsel = 1 selects tmr_b and cfg_tsel = 0 selects tmr_a, zero-extended to 32 bits.
- R7: The FIFO holds 4 timestamps in arrival order. rd_data shows the oldest entry, or 0 when the FIFO is empty. rd_en removes that entry at the next edge. rd_en while the FIFO is empty has no effect.
- R8: buf_ne is 1 exactly while at least one timestamp is stored.
- R9: An event that arrives while 4 entries are held is discarded, and it sets ovf. This applies even when a read happens in the same cycle. ovf stays set until ovf_clr is asserted or the mode is off, and a new overflow wins over ovf_clr.
- R10: irq is a one-cycle pulse, raised after an edge that stores a timestamp and leaves the fill count equal to cfg_irq_thr + 1.
- R11: cfg_mode 0 or 7 is off. While off, the FIFO is emptied, ovf is cleared, and the prescaler count and first-edge state are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Edge-qualification mode |
| cfg_first_rise | input | 1 | First edge polarity for mode 4 |
| cfg_tsel | input | 1 | Timer select in 16-bit mode |
| cfg_wide | input | 1 | Capture both timers as 32 bits |
| cfg_irq_thr | input | 2 | Interrupt fill level minus one |
| ovf_clr | input | 1 | Clear the overflow flag |
| pin_in | input | 1 | Asynchronous capture pin |
| tmr_a | input | 16 | First time base |
| tmr_b | input | 16 | Second time base |
| rd_en | input | 1 | Pop the oldest timestamp |
| rd_data | output | 32 | Oldest timestamp, 0 when empty |
| buf_ne | output | 1 | FIFO not empty |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Fill-level interrupt pulse |

## Verification
A pin change driven before edge k updates buf_ne, rd_data and the stored value at edge k+2. A read, clear or mode change acts at the first edge after it is driven. irq appears in the cycle after the storing edge. The bench drives every input on the falling clock edge. A behavioural model advances on each rising edge and follows this latency: it keeps a short history of pin samples, a queue of timestamps and a count for the prescaler. All outputs are compared against the model just after each falling edge. Directed checks sample at those same cycle offsets, for example the timer value for the latency check is read in the cycle two edges after the pin change.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_RISE    = 3'd1,
        MODE_FALL    = 3'd2,
        MODE_ANY     = 3'd3,
        MODE_FIRST   = 3'd4,
        MODE_DIV_A   = 3'd5,
        MODE_DIV_B   = 3'd6,
        MODE_OFF_ALT = 3'd7
    } icap_mode_e;

    function automatic logic mode_is_off(input logic [2:0] m);
        return (m == MODE_OFF) || (m == MODE_OFF_ALT);
    endfunction

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], pin};
        rise    = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
        fall    = ~st_q.sh[STAGES-1] & st_q.sh[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icap_qualify.sv
module icap_qualify
    import icap_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       first_rise,
    input  logic       rise,
    input  logic       fall,
    output logic       evt
);
    localparam int PW = (DIV_B > DIV_A) ? $clog2(DIV_B) : $clog2(DIV_A);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic          armed;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] lim;
    logic          use_div;

    always_comb begin
        st_d    = st_q;
        evt     = 1'b0;
        use_div = 1'b0;
        lim     = PW'(DIV_A - 1);
        case (icap_mode_e'(mode))
            MODE_RISE:  evt = rise;
            MODE_FALL:  evt = fall;
            MODE_ANY:   evt = rise | fall;
            MODE_FIRST: begin
                if (st_q.armed) begin
                    evt = rise | fall;
                end else if (first_rise ? rise : fall) begin
                    evt        = 1'b1;
                    st_d.armed = 1'b1;
                end
            end
            MODE_DIV_A: begin
                use_div = 1'b1;
                lim     = PW'(DIV_A - 1);
            end
            MODE_DIV_B: begin
                use_div = 1'b1;
                lim     = PW'(DIV_B - 1);
            end
            default: begin
                st_d.pre   = '0;
                st_d.armed = 1'b0;
            end
        endcase
        if (use_div && rise) begin
            if (st_q.pre == lim) begin
                evt      = 1'b1;
                st_d.pre = '0;
            end else begin
                st_d.pre = st_q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          ovf_clr,
    input  logic [AW-1:0] thr,
    output logic [DW-1:0] rdata,
    output logic          ne,
    output logic          ovf,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rp;
        logic [AW-1:0]            wp;
        logic [CW-1:0]            cnt;
        logic                     ovf;
        logic                     irq;
    } st_t;

    st_t  st_d, st_q;
    logic full, push, pop;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        full     = (st_q.cnt == CW'(DEPTH));
        pop      = rd && (st_q.cnt != '0);
        push     = wr && !full;
        if (clear) begin
            st_d = '0;
        end else begin
            if (pop) begin
                st_d.rp = st_q.rp + AW'(1);
            end
            if (push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = st_q.wp + AW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
            if (wr && full)   st_d.ovf = 1'b1;
            else if (ovf_clr) st_d.ovf = 1'b0;
            st_d.irq = push && (st_d.cnt == (CW'(thr) + CW'(1)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ne    = (st_q.cnt != '0);
    assign rdata = ne ? st_q.mem[st_q.rp] : '0;
    assign ovf   = st_q.ovf;
    assign irq   = st_q.irq;
endmodule

// File: rtl/input_capture_chan.sv
module input_capture_chan
    import icap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_A       = 4,
    parameter int DIV_B       = 16,
    parameter int THRW        = $clog2(DEPTH),
    parameter int DW          = 2 * TW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cfg_mode,
    input  logic            cfg_first_rise,
    input  logic            cfg_tsel,
    input  logic            cfg_wide,
    input  logic [THRW-1:0] cfg_irq_thr,
    input  logic            ovf_clr,
    input  logic            pin_in,
    input  logic [TW-1:0]   tmr_a,
    input  logic [TW-1:0]   tmr_b,
    input  logic            rd_en,
    output logic [DW-1:0]   rd_data,
    output logic            buf_ne,
    output logic            ovf,
    output logic            irq
);
    logic          pin_rise, pin_fall, cap_evt, chan_off;
    logic [DW-1:0] cap_val;

    icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_in),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    icap_qualify #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_mode),
        .first_rise(cfg_first_rise),
        .rise      (pin_rise),
        .fall      (pin_fall),
        .evt       (cap_evt)
    );

    always_comb begin
        chan_off = mode_is_off(cfg_mode);
        if (cfg_wide) cap_val = {tmr_b, tmr_a};
        else          cap_val = {{(DW-TW){1'b0}}, (cfg_tsel ? tmr_b : tmr_a)};
    end

    icap_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(THRW)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (chan_off),
        .wr     (cap_evt),
        .wdata  (cap_val),
        .rd     (rd_en),
        .ovf_clr(ovf_clr),
        .thr    (cfg_irq_thr),
        .rdata  (rd_data),
        .ne     (buf_ne),
        .ovf    (ovf),
        .irq    (irq)
    );
endmodule

// File: rtl/icap_chk.sv
module icap_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cfg_mode,
    input logic          ovf_clr,
    input logic          rd_en,
    input logic          cap_evt,
    input logic [DW-1:0] rd_data,
    input logic          buf_ne,
    input logic          ovf,
    input logic          irq
);
    logic off;
    assign off = (cfg_mode == 3'd0) || (cfg_mode == 3'd7);

    assert_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> (!buf_ne && !ovf && !irq));

    assert_irq_has_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> buf_ne);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr && !off) |=> ovf);

    assert_ovf_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !cap_evt && !off) |=> !ovf);

    assert_ovf_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> buf_ne);

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_ne |-> (rd_data == '0));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_ne && rd_en && !cap_evt) |=> !buf_ne);
endmodule

bind input_capture_chan icap_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_mode(cfg_mode),
    .ovf_clr (ovf_clr),
    .rd_en   (rd_en),
    .cap_evt (cap_evt),
    .rd_data (rd_data),
    .buf_ne  (buf_ne),
    .ovf     (ovf),
    .irq     (irq)
);

// File: tb/tb_input_capture_chan.sv
`timescale 1ns/1ps
module tb_input_capture_chan;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  cfg_mode = 0;
    logic        cfg_first_rise = 0, cfg_tsel = 0, cfg_wide = 0;
    logic [1:0]  cfg_irq_thr = 0;
    logic        ovf_clr = 0, pin_in = 0, rd_en = 0;
    logic [15:0] tmr_a = 0, tmr_b = 0;
    logic [31:0] rd_data;
    logic        buf_ne, ovf, irq;

    int checks = 0, errors = 0, irq_seen = 0;

    always #5 clk = ~clk;

    input_capture_chan dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_first_rise(cfg_first_rise),
        .cfg_tsel(cfg_tsel), .cfg_wide(cfg_wide), .cfg_irq_thr(cfg_irq_thr),
        .ovf_clr(ovf_clr), .pin_in(pin_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .rd_en(rd_en), .rd_data(rd_data), .buf_ne(buf_ne), .ovf(ovf), .irq(irq)
    );

    always @(negedge clk) begin
        tmr_a <= tmr_a + 16'd1;
        tmr_b <= tmr_b + 16'd3;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] mq[$];
    bit  p1, p2, p3, m_ovf, m_irq, armed;
    int  pre;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); p1 = 0; p2 = 0; p3 = 0; m_ovf = 0; m_irq = 0; armed = 0; pre = 0;
        end else begin
            bit r, f, ev, full, pop;
            logic [31:0] val;
            r = p2 && !p3; f = !p2 && p3; ev = 0; m_irq = 0;
            if (cfg_mode == 0 || cfg_mode == 7) begin
                mq.delete(); m_ovf = 0; pre = 0; armed = 0;
            end else begin
                case (cfg_mode)
                    1: ev = r;
                    2: ev = f;
                    3: ev = r | f;
                    4: if (armed) ev = r | f;
                       else if (cfg_first_rise ? r : f) begin ev = 1; armed = 1; end
                    5: if (r) begin pre++; if (pre == 4) begin ev = 1; pre = 0; end end
                    6: if (r) begin pre++; if (pre == 16) begin ev = 1; pre = 0; end end
                    default: ;
                endcase
                full = (mq.size() == 4);
                pop  = rd_en && (mq.size() > 0);
                val  = cfg_wide ? {tmr_b, tmr_a} : {16'h0, cfg_tsel ? tmr_b : tmr_a};
                if (pop) void'(mq.pop_front());
                if (ev && !full) begin
                    mq.push_back(val);
                    m_irq = (mq.size() == int'(cfg_irq_thr) + 1);
                end
                if (ev && full) m_ovf = 1;
                else if (ovf_clr) m_ovf = 0;
            end
            p3 = p2; p2 = p1; p1 = pin_in;
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R8 not-empty flag", {31'h0, buf_ne}, {31'h0, mq.size() != 0});
            chk("R6 R7 head timestamp", rd_data, (mq.size() != 0) ? mq[0] : 32'h0);
            chk("R9 overflow flag", {31'h0, ovf}, {31'h0, m_ovf});
            chk("R10 interrupt", {31'h0, irq}, {31'h0, m_irq});
            if (irq) irq_seen++;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_in = 1; wait_n(4);
            pin_in = 0; wait_n(4);
        end
        wait_n(4);
    endtask

    task automatic set_mode(input logic [2:0] m);
        cfg_mode = 0; wait_n(2);
        cfg_mode = m; wait_n(1);
    endtask

    task automatic drain(output int n);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (buf_ne) begin rd_en = 1; n++; end
            else rd_en = 0;
        end
        @(negedge clk); rd_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] expv;
        wait_n(3);
        rst_n = 1;
        wait_n(1); #2;
        chk("R1 reset buf_ne", {31'h0, buf_ne}, 32'h0);
        chk("R1 reset ovf", {31'h0, ovf}, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
        chk("R1 reset rd_data", rd_data, 32'h0);

        // R2 latency and sampled value
        set_mode(3'd1);
        @(negedge clk); pin_in = 1;
        wait_n(2); #2;
        expv = {16'h0, tmr_a};
        chk("R2 not yet stored", {31'h0, buf_ne}, 32'h0);
        wait_n(1); #2;
        chk("R2 stored after two edges", {31'h0, buf_ne}, 32'h1);
        chk("R2 captured timer value", rd_data, expv);
        wait_n(3); pin_in = 0; wait_n(4);
        drain(n);

        // R3 rising only
        set_mode(3'd1); pulses(3); drain(n);
        chk("R3 rising count", n, 3);
        // R3 falling only
        set_mode(3'd2); pulses(2); drain(n);
        chk("R3 falling count", n, 2);
        // R3 both edges, R6 second timer
        cfg_tsel = 1;
        set_mode(3'd3); pulses(2);
        #2 chk("R6 upper half zero in 16-bit mode", {16'h0, rd_data[31:16]}, 32'h0);
        drain(n);
        chk("R3 any-edge count", n, 4);
        // R4 first edge falling, R6 wide
        cfg_tsel = 0; cfg_wide = 1; cfg_first_rise = 0;
        set_mode(3'd4); pulses(2); drain(n);
        chk("R4 first-edge count", n, 3);
        cfg_first_rise = 1;
        set_mode(3'd4); pulses(1); drain(n);
        chk("R4 first-edge rising count", n, 2);
        cfg_wide = 0;
        // R5 prescalers
        set_mode(3'd5); pulses(9); drain(n);
        chk("R5 divide-by-4 count", n, 2);
        set_mode(3'd6); pulses(17); drain(n);
        chk("R5 divide-by-16 count", n, 1);
        set_mode(3'd5); pulses(2);
        set_mode(3'd5); pulses(6); drain(n);
        chk("R5 prescaler restarts after off", n, 1);

        // R9 overflow, R10 with threshold 4
        cfg_irq_thr = 3; irq_seen = 0;
        set_mode(3'd1); pulses(6);
        #2 chk("R9 ovf set on full", {31'h0, ovf}, 32'h1);
        chk("R10 one pulse at level 4", irq_seen, 1);
        drain(n);
        chk("R7 depth four", n, 4);
        #2 chk("R9 ovf sticky after reads", {31'h0, ovf}, 32'h1);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; #2;
        chk("R9 ovf cleared", {31'h0, ovf}, 32'h0);

        // R10 threshold 2
        cfg_irq_thr = 1; irq_seen = 0;
        set_mode(3'd1); pulses(3);
        chk("R10 one pulse at level 2", irq_seen, 1);
        drain(n);

        // R7 read while empty ignored
        @(negedge clk); rd_en = 1; wait_n(3); rd_en = 0;
        pulses(1); drain(n);
        chk("R7 empty read ignored", n, 1);

        // R11 off clears
        pulses(5);
        #2 chk("R11 ovf before off", {31'h0, ovf}, 32'h1);
        @(negedge clk); cfg_mode = 0; @(negedge clk); #2;
        chk("R11 buf_ne cleared", {31'h0, buf_ne}, 32'h0);
        chk("R11 ovf cleared", {31'h0, ovf}, 32'h0);
        wait_n(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule